// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block produces the column addresses of one memory burst, one per clock, starting from the column given with a read or write command. A command is a one-cycle `start_i` pulse. It carries a start column, a burst length code and an order bit. The order bit selects either a linear count that wraps inside an aligned block or an XOR-scrambled order. A full-page length walks every column of the row until the burst is told to stop.

A burst in flight can be cut short on any cycle. A `stop_i` pulse ends it, and a fresh `start_i` replaces it with a new sequence from the new start column. A command that asks for a length/order pair the block cannot serve is rejected. The rejection shows on `illegal_o`, and the command produces no addresses. Outputs are registered, so the first address of a burst appears on the cycle after its command is sampled.

Top module: `burst_col_seq`

## Requirements
- R1: After reset, and with no command given, `valid_o`, `last_o` and `illegal_o` are low.
- R2: A legal command sampled at an edge makes `valid_o` high after that edge, with `col_o` equal to the sampled start column.
- R3: With `ilv_i`=0 and `len_code_i` = 0, 1, 2 or 3, the burst has N = 1, 2, 4 or 8 addresses. Address k keeps the upper column bits of the start column, and its low log2(N) bits equal the start column's low bits plus k, modulo N.
- R4: With `ilv_i`=1 and `len_code_i` = 0..3 (N = 1, 2, 4, 8), address k equals the start column XOR k, for k = 0..N-1.
- R5: `len_code_i`=7 combined with `ilv_i`=1 is illegal, and codes 4, 5 and 6 are illegal with either order. An illegal command raises `illegal_o` for exactly one cycle after it is sampled, produces no valid cycle, and ends any burst in flight.
- R6: `len_code_i`=7 with `ilv_i`=0 is full page. The column counts upward by one each cycle, wraps from 511 to 0, and continues until a stop or a new command arrives.
- R7: `last_o` is high on the final address of every finite burst and on no other cycle. `valid_o` is low on the cycle after it unless a new command arrived.
- R8: A length of 1 gives exactly one valid cycle, and `last_o` is high on that cycle.
- R9: A `stop_i` sampled at an edge makes `valid_o` low after that edge. A stop while idle has no visible effect.
- R10: A command sampled during a burst discards the old burst and starts the new one from its own start column on the next cycle. When `start_i` and `stop_i` coincide, the command wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Command strobe, one cycle |
| start_col_i | input | 9 | Start column of the command |
| len_code_i | input | 3 | Burst length code (0..3 finite, 7 full page) |
| ilv_i | input | 1 | Order: 0 linear wrap, 1 XOR order |
| stop_i | input | 1 | Burst terminate strobe |
| col_o | output | 9 | Current column address |
| valid_o | output | 1 | `col_o` holds a burst address |
| last_o | output | 1 | Final address of a finite burst |
| illegal_o | output | 1 | Previous command was rejected |

## Verification
The assertions take `start_i`, `stop_i` and the command fields to be stable, known values at each rising edge. They also take any value to be permitted on `start_col_i` whenever `start_i` is low. The bench changes every input only on the falling edge and drives `start_i` and `stop_i` as single-cycle pulses. It returns both strobes to zero between commands, so each sampled command is unambiguous. Commands are placed back to back, mid-burst and at coincident stop/start cycles, so the preemption and priority rules are exercised within those assumptions.

// File: rtl/bcs_pkg.sv
package bcs_pkg;
  localparam int unsigned LEN_W    = 3;
  localparam logic [2:0]  LEN_FULL = 3'b111;
endpackage

// File: rtl/bcs_len_decode.sv
module bcs_len_decode
  import bcs_pkg::*;
#(
  parameter int unsigned COL_W = 9
) (
  input  logic [LEN_W-1:0] len_i,
  input  logic             ilv_i,
  output logic             legal_o,
  output logic             full_o,
  output logic [COL_W-1:0] mask_o
);
  assign full_o  = (len_i == LEN_FULL);
  assign legal_o = !len_i[2] || (full_o && !ilv_i);

  // mask bit b set when b < code (finite) or always (full page)
  for (genvar b = 0; b < COL_W; b++) begin : g_mask
    assign mask_o[b] = full_o || (!len_i[2] && (32'(len_i[1:0]) > b));
  end
endmodule

// File: rtl/bcs_col_gen.sv
module bcs_col_gen #(
  parameter int unsigned COL_W = 9
) (
  input  logic [COL_W-1:0] base_i,
  input  logic [COL_W-1:0] cnt_i,
  input  logic [COL_W-1:0] mask_i,
  input  logic             ilv_i,
  output logic [COL_W-1:0] col_o
);
  logic [COL_W-1:0] mix;

  always_comb begin
    if (ilv_i) mix = base_i ^ cnt_i;
    else       mix = base_i + cnt_i;
    col_o = (base_i & ~mask_i) | (mix & mask_i);
  end
endmodule

// File: rtl/bcs_ctrl.sv
module bcs_ctrl #(
  parameter int unsigned COL_W = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic [COL_W-1:0] col_i,
  input  logic             legal_i,
  input  logic             full_i,
  input  logic             ilv_i,
  input  logic [COL_W-1:0] mask_i,
  output logic             active_o,
  output logic [COL_W-1:0] base_o,
  output logic [COL_W-1:0] cnt_o,
  output logic [COL_W-1:0] mask_o,
  output logic             ilv_o,
  output logic             last_o,
  output logic             illegal_o
);
  logic full_q;

  assign last_o = active_o && !full_q && (cnt_o == mask_o);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_o  <= 1'b0;
      base_o    <= '0;
      cnt_o     <= '0;
      mask_o    <= '0;
      ilv_o     <= 1'b0;
      full_q    <= 1'b0;
      illegal_o <= 1'b0;
    end else if (start_i) begin
      // new command preempts any burst and any stop
      active_o  <= legal_i;
      illegal_o <= !legal_i;
      base_o    <= col_i;
      cnt_o     <= '0;
      mask_o    <= mask_i;
      ilv_o     <= ilv_i;
      full_q    <= full_i;
    end else begin
      illegal_o <= 1'b0;
      if (stop_i || last_o) active_o <= 1'b0;
      else if (active_o)    cnt_o    <= cnt_o + 1'b1;
    end
  end
endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq
  import bcs_pkg::*;
#(
  parameter int unsigned COL_W = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [COL_W-1:0] start_col_i,
  input  logic [LEN_W-1:0] len_code_i,
  input  logic             ilv_i,
  input  logic             stop_i,
  output logic [COL_W-1:0] col_o,
  output logic             valid_o,
  output logic             last_o,
  output logic             illegal_o
);
  logic             dec_legal, dec_full, ilv_q;
  logic [COL_W-1:0] dec_mask, base_q, cnt_q, mask_q;

  bcs_len_decode #(.COL_W(COL_W)) i_dec (
    .len_i   (len_code_i),
    .ilv_i   (ilv_i),
    .legal_o (dec_legal),
    .full_o  (dec_full),
    .mask_o  (dec_mask)
  );

  bcs_ctrl #(.COL_W(COL_W)) i_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .stop_i    (stop_i),
    .col_i     (start_col_i),
    .legal_i   (dec_legal),
    .full_i    (dec_full),
    .ilv_i     (ilv_i),
    .mask_i    (dec_mask),
    .active_o  (valid_o),
    .base_o    (base_q),
    .cnt_o     (cnt_q),
    .mask_o    (mask_q),
    .ilv_o     (ilv_q),
    .last_o    (last_o),
    .illegal_o (illegal_o)
  );

  bcs_col_gen #(.COL_W(COL_W)) i_gen (
    .base_i (base_q),
    .cnt_i  (cnt_q),
    .mask_i (mask_q),
    .ilv_i  (ilv_q),
    .col_o  (col_o)
  );
endmodule

// File: rtl/bcs_checker.sv
module bcs_checker
  import bcs_pkg::*;
#(
  parameter int unsigned COL_W = 9
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic [COL_W-1:0] start_col_i,
  input logic [LEN_W-1:0] len_code_i,
  input logic             ilv_i,
  input logic             stop_i,
  input logic [COL_W-1:0] col_o,
  input logic             valid_o,
  input logic             last_o,
  input logic             illegal_o
);
  logic cmd_ok, cmd_full, in_full;

  assign cmd_full = (len_code_i == LEN_FULL) && !ilv_i;
  assign cmd_ok   = !len_code_i[2] || cmd_full;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      in_full <= 1'b0;
    else if (start_i) in_full <= cmd_full;
    else if (stop_i)  in_full <= 1'b0;
  end

  AST_START_FIRST_COL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && cmd_ok |=> valid_o && col_o == $past(start_col_i)); // R2
  AST_BAD_CMD_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !cmd_ok |=> illegal_o && !valid_o); // R5
  AST_FLAG_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> !illegal_o); // R5
  AST_FULL_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_full && valid_o && !start_i && !stop_i |=> valid_o && col_o == $past(col_o) + 1'b1); // R6
  AST_FULL_NO_LAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_full |-> !last_o); // R6
  AST_LAST_ENDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o && !start_i |=> !valid_o); // R7
  AST_LAST_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o |-> valid_o); // R7
  AST_SINGLE_LAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && len_code_i == 3'd0 |=> last_o); // R8
  AST_STOP_ENDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i && !start_i |=> !valid_o); // R9
endmodule

bind burst_col_seq bcs_checker #(.COL_W(COL_W)) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_i     (start_i),
  .start_col_i (start_col_i),
  .len_code_i  (len_code_i),
  .ilv_i       (ilv_i),
  .stop_i      (stop_i),
  .col_o       (col_o),
  .valid_o     (valid_o),
  .last_o      (last_o),
  .illegal_o   (illegal_o)
);

// File: tb/test_burst_col_seq.sv
`timescale 1ns/1ps
module test_burst_col_seq;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       start_i = 1'b0, ilv_i = 1'b0, stop_i = 1'b0;
  logic [8:0] start_col_i = '0;
  logic [2:0] len_code_i = '0;
  logic [8:0] col_o;
  logic       valid_o, last_o, illegal_o;

  int n_tests = 0, n_fail = 0;
  bit done = 1'b0;

  typedef struct {
    logic       v;
    logic [8:0] c;
    logic       l;
    logic       i;
    string      tag;
  } exp_t;
  exp_t q[$];

  always #2 clk_i = ~clk_i;

  burst_col_seq i_burst_col_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .start_col_i(start_col_i),
    .len_code_i(len_code_i), .ilv_i(ilv_i), .stop_i(stop_i),
    .col_o(col_o), .valid_o(valid_o), .last_o(last_o), .illegal_o(illegal_o)
  );

  // monitor: one expected item per clock edge
  always begin
    @(posedge clk_i);
    #1;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      n_tests++;
      if (valid_o !== e.v || illegal_o !== e.i || last_o !== e.l ||
          (e.v && col_o !== e.c)) begin
        n_fail++;
        $display("FAIL %s: got v=%0b c=%0d l=%0b i=%0b exp v=%0b c=%0d l=%0b i=%0b",
                 e.tag, valid_o, col_o, last_o, illegal_o, e.v, e.c, e.l, e.i);
      end
    end
  end

  task automatic step(input logic st, input logic [8:0] c, input logic [2:0] l,
                      input logic t, input logic sp, input logic ev,
                      input logic [8:0] ec, input logic el, input logic ei,
                      input string tag);
    exp_t e;
    @(negedge clk_i);
    start_i = st; start_col_i = c; len_code_i = l; ilv_i = t; stop_i = sp;
    e.v = ev; e.c = ec; e.l = el; e.i = ei; e.tag = tag;
    q.push_back(e);
  endtask

  // command then run-1 idle cycles; expected addresses from R3/R4/R6 formulas
  task automatic burst(input logic [8:0] s, input logic [2:0] code, input logic t,
                       input int run, input logic with_stop, input string tag);
    bit         full = (code == 3'd7);
    int         n = full ? 0 : (1 << code);
    logic [8:0] m = full ? 9'h1FF : 9'(n - 1);
    for (int k = 0; k < run; k++) begin
      logic [8:0] kk = 9'(k);
      logic [8:0] ec = t ? (s ^ kk) : ((s & ~m) | ((s + kk) & m));
      logic       ev = full || (k < n);
      logic       el = !full && (k == n - 1);
      if (k == 0) step(1'b1, s, code, t, with_stop, ev, ec, el, 1'b0, tag);
      else        step(1'b0, 9'd0, 3'd0, 1'b0, 1'b0, ev, ec, el, 1'b0, tag);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: got hang exp completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    #1;
    n_tests++;
    if (valid_o !== 1'b0 || last_o !== 1'b0 || illegal_o !== 1'b0) begin
      n_fail++;
      $display("FAIL R1 reset: got v=%0b l=%0b i=%0b exp 0 0 0", valid_o, last_o, illegal_o);
    end
    step(0, 9'd0, 3'd0, 0, 0, 0, 9'd0, 0, 0, "R1 idle");

    burst(9'd13, 3'd3, 1'b0, 10, 1'b0, "R3 R7 seq8");
    burst(9'd13, 3'd3, 1'b1, 10, 1'b0, "R4 R7 ilv8");
    burst(9'd6,  3'd2, 1'b0, 6,  1'b0, "R3 seq4");
    burst(9'd6,  3'd2, 1'b1, 6,  1'b0, "R4 ilv4");
    burst(9'd301, 3'd1, 1'b0, 3, 1'b0, "R3 seq2");
    burst(9'd301, 3'd1, 1'b1, 3, 1'b0, "R4 ilv2");
    burst(9'd77, 3'd0, 1'b0, 3, 1'b0, "R8 len1 seq");
    burst(9'd78, 3'd0, 1'b1, 2, 1'b0, "R8 len1 ilv");

    burst(9'd509, 3'd7, 1'b0, 6, 1'b0, "R6 full wrap");
    step(0, 9'd0, 3'd0, 0, 1, 0, 9'd0, 0, 0, "R9 stop full");
    step(0, 9'd0, 3'd0, 0, 1, 0, 9'd0, 0, 0, "R9 stop idle");
    step(0, 9'd0, 3'd0, 0, 0, 0, 9'd0, 0, 0, "R9 idle after");

    burst(9'd0,   3'd3, 1'b0, 3, 1'b0, "R10 first");
    burst(9'd100, 3'd2, 1'b1, 6, 1'b0, "R10 restart");
    burst(9'd40,  3'd3, 1'b0, 2, 1'b0, "R10 pre-stop");
    burst(9'd200, 3'd1, 1'b0, 3, 1'b1, "R10 start+stop");

    burst(9'd20, 3'd3, 1'b0, 2, 1'b0, "R5 before");
    step(1, 9'd33, 3'd7, 1, 0, 0, 9'd0, 0, 1, "R5 full ilv");
    step(0, 9'd0, 3'd0, 0, 0, 0, 9'd0, 0, 0, "R5 after");
    step(1, 9'd33, 3'd5, 0, 0, 0, 9'd0, 0, 1, "R5 code5");
    step(0, 9'd0, 3'd0, 0, 0, 0, 9'd0, 0, 0, "R5 after2");

    burst(9'd58, 3'd3, 1'b1, 3, 1'b0, "R9 mid");
    step(0, 9'd0, 3'd0, 0, 1, 0, 9'd0, 0, 0, "R9 stop mid");
    step(0, 9'd0, 3'd0, 0, 0, 0, 9'd0, 0, 0, "R9 stays idle");

    step(0, 9'd0, 3'd0, 0, 0, 0, 9'd0, 0, 0, "R1 tail");
    wait (q.size() == 0);
    repeat (2) @(posedge clk_i);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule